// File: doc/BRIEF.md
# Eye-Signature Sweep Phase Controller

This controller handles phase alignment for one receive lane of a source-synchronous link. Two sampling paths run at once. One is the data path, which recovers the bits. The other is the search path, whose phase code is stepped from 0 upward across a delay range of two unit intervals. At every step the block takes one match/mismatch decision, which says whether the search sample agreed with the data sample. It writes that decision into a raw signature, a binary picture of the eye. A morphological filter cleans the raw signature. The block then looks for the opening and closing edges of an eye in the filtered signature.

When a whole eye is seen, the block places the new data phase at the midpoint of that eye. In the same cycle it swaps the roles of the two paths, so the path that was just positioned becomes the data path. Every sweep therefore re-aims the idle path and hands it over, and the lane can follow a phase drift of any size.

A normal sweep ends as soon as the eye is confirmed. If no eye is found before the end of the range, the block flags lost lock and runs a sweep over the whole range. When that sweep finds the neighbouring eye, the block inverts the clock-edge polarity to complete a one-UI shift. A full sweep can also be requested for calibration. A full sweep measures the spacing between the ends of two consecutive eyes and raises a calibration request when that spacing is not close to half the range.

Top module: `eye_sweep_ctrl`

## Requirements
- R1: After reset, `search_code`, `data_code`, `path_sel`, `edge_pol`, `upd_pulse`, `lost_lock` and `cal_req` are all 0.
- R2: Each decision accepted while sweeping (`dec_vld`=1) stores `dec_mis` (1 = mismatch, 0 = match) at index `search_code` and raises `search_code` by one. The cycle after an accepted decision is an evaluation cycle, and `dec_vld` has no effect in that cycle.
- R3: The raw signature passes through four 3-tap passes, with end bits replicated. The passes are: a mismatch-OR, a mismatch-AND, a mismatch-AND, then a mismatch-OR. A single inverted decision inside a run of three or more equal bits therefore does not move any detected edge.
- R4: The eye opening `a` is the first filtered index i ≥ 1 where bit i-1 is mismatch and bit i is match. The eye closing `b` is the first index after `a` where bit b-1 is match and bit b is mismatch. A normal sweep ends once the decision at index b+4 has been accepted, after b+5 decisions.
- R5: On an update, `data_code` becomes floor((a+b)/2).
- R6: An update raises `upd_pulse` for one cycle. In that same cycle `path_sel` toggles, `data_code` takes its new value and `search_code` returns to 0. `path_sel` and `data_code` change at no other time.
- R7: If a normal sweep reaches 64 decisions without finding a closed eye, `lost_lock` pulses for one cycle, `search_code` returns to 0 and the next sweep is a full one. A full sweep always takes all 64 decisions.
- R8: When a full sweep started by lost lock finds an eye, `edge_pol` toggles with the update. `edge_pol` does not change in any other case.
- R9: A one-cycle pulse on `cal_need` makes the sweep that follows the next update a full sweep. An update from that full sweep leaves `edge_pol` unchanged.
- R10: When a full sweep updates, the block looks for the next closing edge `e` after `b`. If `e` exists, `cal_req` becomes 1 when e−b lies outside 32±4 and becomes 0 otherwise.
- R11: A full sweep that finds no closed eye pulses `lost_lock` again, and the next sweep is full again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_vld | input | 1 | Decision strobe |
| dec_mis | input | 1 | Decision value, 1 = mismatch |
| cal_need | input | 1 | Request a full calibration sweep |
| search_code | output | 6 | Phase code of the search path |
| data_code | output | 6 | Phase code of the data path |
| path_sel | output | 1 | Which physical path acts as data |
| edge_pol | output | 1 | Clock-edge polarity, toggled on a one-UI shift |
| upd_pulse | output | 1 | One-cycle pulse on a phase update and role swap |
| lost_lock | output | 1 | One-cycle pulse when a sweep finds no eye |
| cal_req | output | 1 | Delay range needs calibration |

## Verification
The assertions check on every cycle that the update and lost-lock pulses never coincide. They also check that `path_sel` and `data_code` change only with an update, that the polarity changes only on an update, that every pulse leaves the search code at 0, and that the sweep count only steps by one or clears.

Only the bench scenarios can show the values themselves. These are the stopping point of the early exit, the midpoint arithmetic, the removal of noisy decisions by the filter, the choice between normal and full sweeps after loss or a calibration request, and the spacing test behind `cal_req`.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic {
    ST_SWEEP = 1'b0,
    ST_EVAL  = 1'b1
  } esc_state_t;

  typedef enum logic [1:0] {
    MODE_TRACK     = 2'd0,
    MODE_FULL_LOSS = 2'd1,
    MODE_FULL_CAL  = 2'd2
  } esc_mode_t;

endpackage

// File: rtl/esc_sig_capture.sv
module esc_sig_capture #(
  parameter int N  = 64,
  parameter int CW = 6,
  parameter int NW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          clr,
  input  logic          wr_bit,
  output logic [NW-1:0] cnt,
  output logic [N-1:0]  ext
);

  logic [N-1:0] raw_q;
  logic         last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      raw_q  <= '0;
      last_q <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr_en) begin
      raw_q[cnt[CW-1:0]] <= wr_bit;
      cnt                <= cnt + 1'b1;
      last_q             <= wr_bit;
    end
  end

  // Unwritten positions copy the most recent decision, so bits far enough
  // behind the write point filter exactly as in a finished sweep.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      ext[i] = (NW'(i) < cnt) ? raw_q[i] : last_q;
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

  p_cnt_max_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= NW'(N));

endmodule

// File: rtl/esc_morph_pass.sv
module esc_morph_pass #(
  parameter int N      = 64,
  parameter bit USE_OR = 1'b1
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_tap
      localparam int L = (i == 0) ? 0 : i - 1;
      localparam int R = (i == N - 1) ? N - 1 : i + 1;
      if (USE_OR) begin : g_or
        assign dout[i] = din[L] | din[i] | din[R];
      end else begin : g_and
        assign dout[i] = din[L] & din[i] & din[R];
      end
    end
  endgenerate

endmodule

// File: rtl/esc_sig_filter.sv
module esc_sig_filter #(
  parameter int                   N       = 64,
  parameter int                   PASSES  = 4,
  parameter logic [PASSES-1:0]    OR_MASK = 4'b1001
) (
  input  logic [N-1:0] raw_mis,
  output logic [N-1:0] filt_mis
);

  logic [N-1:0] stage [PASSES+1];

  assign stage[0] = raw_mis;

  genvar p;
  generate
    for (p = 0; p < PASSES; p++) begin : g_pass
      esc_morph_pass #(
        .N      (N),
        .USE_OR (OR_MASK[p])
      ) u_pass (
        .din  (stage[p]),
        .dout (stage[p+1])
      );
    end
  endgenerate

  assign filt_mis = stage[PASSES];

endmodule

// File: rtl/esc_edge_scan.sv
module esc_edge_scan #(
  parameter int N  = 64,
  parameter int CW = 6,
  parameter int NW = 7
) (
  input  logic [N-1:0]  sig_mis,
  input  logic [NW-1:0] valid_n,
  output logic          eye_ok,
  output logic [CW-1:0] pos_open,
  output logic [CW-1:0] pos_close,
  output logic          next_ok,
  output logic [CW-1:0] pos_next
);

  logic open_f;

  always_comb begin
    open_f    = 1'b0;
    eye_ok    = 1'b0;
    next_ok   = 1'b0;
    pos_open  = '0;
    pos_close = '0;
    pos_next  = '0;
    for (int i = 1; i < N; i++) begin
      if (i < int'(valid_n)) begin
        if (!open_f) begin
          if (sig_mis[i-1] && !sig_mis[i]) begin
            open_f   = 1'b1;
            pos_open = CW'(i);
          end
        end else if (!eye_ok) begin
          if (!sig_mis[i-1] && sig_mis[i]) begin
            eye_ok    = 1'b1;
            pos_close = CW'(i);
          end
        end else if (!next_ok) begin
          if (!sig_mis[i-1] && sig_mis[i]) begin
            next_ok  = 1'b1;
            pos_next = CW'(i);
          end
        end
      end
    end
  end

endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl #(
  parameter int CODE_W  = 6,
  parameter int PASSES  = 4,
  parameter int CAL_TOL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_vld,
  input  logic              dec_mis,
  input  logic              cal_need,
  output logic [CODE_W-1:0] search_code,
  output logic [CODE_W-1:0] data_code,
  output logic              path_sel,
  output logic              edge_pol,
  output logic              upd_pulse,
  output logic              lost_lock,
  output logic              cal_req
);
  import esc_pkg::*;

  localparam int STEPS = 1 << CODE_W;
  localparam int NW    = CODE_W + 1;
  localparam int HALF  = STEPS / 2;
  localparam logic [NW-1:0] SPAN_LO = NW'(HALF - CAL_TOL);
  localparam logic [NW-1:0] SPAN_HI = NW'(HALF + CAL_TOL);
  localparam logic [PASSES-1:0] OR_MASK = PASSES'(4'b1001);

  esc_state_t  state_q;
  esc_mode_t   mode_q;
  logic        pend_cal_q;

  logic [NW-1:0]     cnt;
  logic [STEPS-1:0]  ext_sig;
  logic [STEPS-1:0]  filt_sig;
  logic [NW-1:0]     valid_n;
  logic              eye_ok, next_ok;
  logic [CODE_W-1:0] pos_open, pos_close, pos_next;

  logic wr_en, clr, at_end, do_upd, do_lost;
  logic [NW-1:0] sum_ab, span;
  logic          span_bad;

  assign wr_en = (state_q == ST_SWEEP) && dec_vld;
  assign at_end = (cnt == NW'(STEPS));

  esc_sig_capture #(.N(STEPS), .CW(CODE_W), .NW(NW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .clr    (clr),
    .wr_bit (dec_mis),
    .cnt    (cnt),
    .ext    (ext_sig)
  );

  esc_sig_filter #(.N(STEPS), .PASSES(PASSES), .OR_MASK(OR_MASK)) u_filt (
    .raw_mis  (ext_sig),
    .filt_mis (filt_sig)
  );

  // Positions below valid_n no longer depend on decisions yet to come.
  always_comb begin
    if (at_end)                     valid_n = NW'(STEPS);
    else if (cnt > NW'(PASSES))     valid_n = cnt - NW'(PASSES);
    else                            valid_n = '0;
  end

  esc_edge_scan #(.N(STEPS), .CW(CODE_W), .NW(NW)) u_scan (
    .sig_mis   (filt_sig),
    .valid_n   (valid_n),
    .eye_ok    (eye_ok),
    .pos_open  (pos_open),
    .pos_close (pos_close),
    .next_ok   (next_ok),
    .pos_next  (pos_next)
  );

  assign sum_ab   = {1'b0, pos_open} + {1'b0, pos_close};
  assign span     = {1'b0, pos_next} - {1'b0, pos_close};
  assign span_bad = (span < SPAN_LO) || (span > SPAN_HI);

  always_comb begin
    do_upd  = 1'b0;
    do_lost = 1'b0;
    if (state_q == ST_EVAL) begin
      if (mode_q == MODE_TRACK) begin
        do_upd  = eye_ok;
        do_lost = !eye_ok && at_end;
      end else if (at_end) begin
        do_upd  = eye_ok;
        do_lost = !eye_ok;
      end
    end
  end

  assign clr = do_upd || do_lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SWEEP;
      mode_q     <= MODE_TRACK;
      pend_cal_q <= 1'b0;
      data_code  <= '0;
      path_sel   <= 1'b0;
      edge_pol   <= 1'b0;
      upd_pulse  <= 1'b0;
      lost_lock  <= 1'b0;
      cal_req    <= 1'b0;
    end else begin
      upd_pulse <= do_upd;
      lost_lock <= do_lost;
      if (cal_need) pend_cal_q <= 1'b1;
      case (state_q)
        ST_SWEEP: if (dec_vld) state_q <= ST_EVAL;
        default:  state_q <= ST_SWEEP;
      endcase
      if (do_upd) begin
        data_code <= sum_ab[NW-1:1];
        path_sel  <= ~path_sel;
        if (mode_q == MODE_FULL_LOSS) edge_pol <= ~edge_pol;
        if (mode_q != MODE_TRACK && next_ok) cal_req <= span_bad;
        mode_q <= (pend_cal_q || cal_need) ? MODE_FULL_CAL : MODE_TRACK;
        pend_cal_q <= 1'b0;
      end else if (do_lost) begin
        mode_q     <= MODE_FULL_LOSS;
        pend_cal_q <= 1'b0;
      end
    end
  end

  assign search_code = cnt[CODE_W-1:0];

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({upd_pulse, lost_lock}));

  p_path_flip_r6: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (path_sel != $past(path_sel)));

  p_path_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |-> $stable(path_sel));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |-> $stable(data_code));

  p_pol_on_upd_r8: assert property (@(posedge clk) disable iff (rst)
    (edge_pol != $past(edge_pol)) |-> upd_pulse);

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse || lost_lock) |-> (search_code == '0));

endmodule

// File: tb/eye_sweep_ctrl_tb.sv
`timescale 1ns/1ps
module eye_sweep_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_vld = 1'b0;
  logic       dec_mis = 1'b0;
  logic       cal_need = 1'b0;
  logic [5:0] search_code, data_code;
  logic       path_sel, edge_pol, upd_pulse, lost_lock, cal_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  eye_sweep_ctrl u_dut (
    .clk (clk), .rst (rst), .dec_vld (dec_vld), .dec_mis (dec_mis),
    .cal_need (cal_need), .search_code (search_code), .data_code (data_code),
    .path_sel (path_sel), .edge_pol (edge_pol), .upd_pulse (upd_pulse),
    .lost_lock (lost_lock), .cal_req (cal_req)
  );

  // columns: open, close, open2, close2, noise, precal, event(1 upd, 2 lost),
  //          decisions, data, path, pol, cal
  localparam int NV = 10;
  localparam int TV [NV][12] = '{
    '{10, 30,  0,  0, 99, 0, 1, 35, 20, 1, 0, 0},  // R4 R5 R6 plain eye
    '{ 5, 20,  0,  0, 12, 0, 1, 25, 12, 0, 0, 0},  // R3 mismatch noise in eye
    '{40, 56,  0,  0, 99, 0, 1, 61, 48, 1, 0, 0},  // R4 late eye
    '{20, 26,  0,  0,  3, 0, 1, 31, 23, 0, 0, 0},  // R3 match noise outside
    '{ 0, 20,  0,  0, 99, 0, 2, 64, 23, 0, 0, 0},  // R7 eye runs off start
    '{ 0,  0,  0,  0, 99, 0, 2, 64, 23, 0, 0, 0},  // R11 full sweep, no eye
    '{ 8, 24, 40, 56, 99, 0, 1, 64, 16, 1, 1, 0},  // R8 R10 UI swap, spacing 32
    '{10, 30,  0,  0, 99, 1, 1, 35, 20, 0, 1, 0},  // R9 cal request queued
    '{ 4, 20, 30, 40, 99, 0, 1, 64, 12, 1, 1, 1},  // R9 R10 spacing 20
    '{ 6, 12,  0,  0, 99, 0, 1, 17,  9, 0, 1, 1}   // R4 narrow eye
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); dec_vld = 1'b1; dec_mis = b;
    @(negedge clk); dec_vld = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic pat(input int k, input int v);
    logic m;
    m = !((k >= TV[v][0] && k < TV[v][1]) || (k >= TV[v][2] && k < TV[v][3]));
    if (k == TV[v][4]) m = ~m;
    return m;
  endfunction

  task automatic check_reset();
    chk("R1 search_code", int'(search_code), 0);
    chk("R1 data_code", int'(data_code), 0);
    chk("R1 path_sel", int'(path_sel), 0);
    chk("R1 edge_pol", int'(edge_pol), 0);
    chk("R1 pulses", int'({upd_pulse, lost_lock}), 0);
    chk("R1 cal_req", int'(cal_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset();

    for (int v = 0; v < NV; v++) begin
      int ev;
      int n;
      ev = 0;
      n  = 0;
      if (TV[v][5] != 0) begin
        @(negedge clk); cal_need = 1'b1;
        @(negedge clk); cal_need = 1'b0;
      end
      for (int k = 0; k < 64; k++) begin
        chk("R2 search_code step", int'(search_code), k);
        send(pat(k, v));
        if (upd_pulse) ev = 1;
        if (lost_lock) ev = 2;
        if (upd_pulse || lost_lock) begin
          n = k + 1;
          chk("R6 R7 search_code cleared", int'(search_code), 0);
          break;
        end
      end
      chk("R6 R7 event kind", ev, TV[v][6]);
      chk("R4 R7 decisions used", n, TV[v][7]);
      chk("R5 data_code", int'(data_code), TV[v][8]);
      chk("R6 path_sel", int'(path_sel), TV[v][9]);
      chk("R8 R9 edge_pol", int'(edge_pol), TV[v][10]);
      chk("R10 cal_req", int'(cal_req), TV[v][11]);
      @(negedge clk);
      chk("R6 pulse one cycle", int'({upd_pulse, lost_lock}), 0);
    end

    // R2: strobe held into the evaluation cycle counts once
    @(negedge clk); dec_vld = 1'b1; dec_mis = 1'b1;
    @(negedge clk);
    @(negedge clk); dec_vld = 1'b0;
    @(negedge clk);
    chk("R2 strobe in eval ignored", int'(search_code), 1);

    // R1: reset in mid-operation
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule